// File: doc/BRIEF.md
# Shared Endpoint Buffer Allocator

This block divides one 8 KiB packet pool among the endpoints of a USB-style peripheral. There are sixteen endpoint slots. Two are control endpoints, one per direction, and each is fixed at 64 bytes. The other fourteen are data endpoints, seven OUT and seven IN. Software programs the data endpoints one at a time. Each slot holds:
- an enable bit,
- a maximum packet length,
- a double-buffer flag,
- a transfer-type code.

A one-cycle commit pulse starts an allocation walk. The walk visits one slot per clock in slot-number order. Each enabled endpoint receives the next free region of the pool.

While traffic runs, a packet engine asks for an endpoint's current buffer address on a registered lookup port. A double-buffered endpoint owns two back-to-back halves. A packet-done pulse moves that endpoint to its other half, so the producer can fill one half while the consumer drains the other. The walk takes a snapshot of the enable, length and double-buffer settings. Configuration writes made after a commit therefore have no effect on lookups until the next commit.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset, `alloc_done`, `alloc_busy`, `alloc_ovf` and `lk_valid` are all 0.
- R2: A commit pulse sampled on a rising edge sets `alloc_busy` and clears `alloc_done` and `alloc_ovf` on that edge. `alloc_done` rises on the 16th following edge and holds until the next commit.
- R3: The slot numbers are:
  - 0: control OUT
  - 1: control IN
  - 2..8: OUT1..OUT7
  - 9..15: IN1..IN7

  Enabled endpoints are placed in increasing slot order. Each base address equals the sum of the space taken by the earlier allocated slots.
- R4: The two control slots are always allocated, at bases 0 and 64, with a length of 64 bytes. Writes to slots 0 and 1 are ignored.
- R5: A disabled data endpoint takes no pool space, and a lookup on it returns `lk_valid`=0.
- R6: A double-buffered endpoint takes twice its maximum packet length from the pool. A single-buffered endpoint takes exactly its length.
- R7: An enabled endpoint that would take the running total past 8192 bytes raises `alloc_ovf`. That endpoint and every later slot stay unallocated. A total of exactly 8192 is accepted.
- R8: A packet-done pulse on an allocated double-buffered endpoint toggles its half. The lookup address is then base plus length, and `lk_half`=1.
- R9: A packet-done pulse on a single-buffered endpoint changes nothing that a lookup returns.
- R10: A commit returns every endpoint to its first half.
- R11: A lookup returns its result one cycle after `lk_ep` is sampled:
  - `lk_valid` (allocation complete and endpoint allocated)
  - `lk_addr`
  - `lk_len`
  - `lk_half`
  - `lk_type`

  The type codes are 0 control, 1 isochronous, 2 bulk and 3 interrupt. A data slot resets to bulk.
- R12: Enable, length and double-buffer changes written after a commit do not alter lookups until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Slot being configured |
| cfg_en | input | 1 | Enable bit to store |
| cfg_mps | input | 11 | Maximum packet length in bytes |
| cfg_dbl | input | 1 | Double-buffer flag to store |
| cfg_type | input | 2 | Transfer-type code to store |
| commit | input | 1 | Starts an allocation walk |
| alloc_busy | output | 1 | Walk in progress |
| alloc_done | output | 1 | Walk complete |
| alloc_ovf | output | 1 | Pool exhausted during the last walk |
| pkt_done | input | 1 | Packet completed on `pkt_ep` |
| pkt_ep | input | 4 | Slot of the completed packet |
| lk_ep | input | 4 | Slot to look up |
| lk_valid | output | 1 | Looked-up slot holds a buffer |
| lk_addr | output | 13 | Current buffer byte address |
| lk_len | output | 11 | Buffer length in bytes |
| lk_half | output | 1 | Active half of a double buffer |
| lk_type | output | 2 | Stored transfer type |

## Verification
The assertions check, on every cycle, that:
- a commit clears the completion and overflow flags and starts the walk;
- completion and overflow hold steady between commits;
- a valid lookup never reaches past the end of the pool;
- control slots always report 64 bytes in their first half.

The exact placement of each endpoint depends on the whole configuration, and the checker does not model it. The bench's scenarios cover:
- exact placement, including skipped disabled slots and doubled space;
- the exact-fit and overflow boundaries;
- half toggling, and its reset by a commit;
- configuration writes that must wait for the next commit.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  typedef enum logic [1:0] {
    XF_CTRL = 2'd0,
    XF_ISO  = 2'd1,
    XF_BULK = 2'd2,
    XF_INTR = 2'd3
  } xfer_t;

  localparam int unsigned CTRL_SLOTS = 2;
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_alloc_pkg::*;
#(
  parameter int N_EP       = 16,
  parameter int EP_W       = 4,
  parameter int MPS_W      = 11,
  parameter int CTRL_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [EP_W-1:0]  cfg_ep,
  input  logic             cfg_en,
  input  logic [MPS_W-1:0] cfg_mps,
  input  logic             cfg_dbl,
  input  logic [1:0]       cfg_type,
  input  logic [EP_W-1:0]  wk_idx,
  output logic             wk_en,
  output logic [MPS_W-1:0] wk_mps,
  output logic             wk_dbl,
  input  logic [EP_W-1:0]  lk_idx,
  output logic [1:0]       lk_type
);
  logic [N_EP-1:0]  en_v;
  logic [N_EP-1:0]  dbl_v;
  logic [MPS_W-1:0] mps_a  [N_EP];
  logic [1:0]       type_a [N_EP];

  for (genvar i = 0; i < N_EP; i++) begin : g_slot
    if (i < CTRL_SLOTS) begin : g_ctrl
      // Control slots are fixed; writes to them are dropped.
      assign en_v[i]   = 1'b1;
      assign dbl_v[i]  = 1'b0;
      assign mps_a[i]  = MPS_W'(CTRL_BYTES);
      assign type_a[i] = XF_CTRL;
    end else begin : g_data
      logic             en_q;
      logic             dbl_q;
      logic [MPS_W-1:0] mps_q;
      logic [1:0]       type_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          dbl_q  <= 1'b0;
          mps_q  <= '0;
          type_q <= XF_BULK;
        end else if (cfg_we && cfg_ep == EP_W'(i)) begin
          en_q   <= cfg_en;
          dbl_q  <= cfg_dbl;
          mps_q  <= cfg_mps;
          type_q <= cfg_type;
        end
      end

      assign en_v[i]   = en_q;
      assign dbl_v[i]  = dbl_q;
      assign mps_a[i]  = mps_q;
      assign type_a[i] = type_q;
    end
  end

  assign wk_en   = en_v[wk_idx];
  assign wk_dbl  = dbl_v[wk_idx];
  assign wk_mps  = mps_a[wk_idx];
  assign lk_type = type_a[lk_idx];
endmodule

// File: rtl/ep_alloc_walker.sv
module ep_alloc_walker #(
  parameter int N_EP      = 16,
  parameter int EP_W      = 4,
  parameter int MPS_W     = 11,
  parameter int ADDR_W    = 13,
  parameter int MEM_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  output logic [EP_W-1:0]   wk_idx,
  input  logic              wk_en,
  input  logic [MPS_W-1:0]  wk_mps,
  input  logic              wk_dbl,
  output logic              busy,
  output logic              done,
  output logic              ovf,
  output logic [N_EP-1:0]   alloc_v,
  output logic [N_EP-1:0]   dbl_v,
  input  logic [EP_W-1:0]   lk_idx,
  output logic [ADDR_W-1:0] lk_base,
  output logic [MPS_W-1:0]  lk_len
);
  localparam int TOT_W = ADDR_W + 2;
  localparam logic [EP_W-1:0] LAST = EP_W'(N_EP - 1);

  logic [TOT_W-1:0]  total_q;
  logic [TOT_W-1:0]  need;
  logic [TOT_W-1:0]  sum;
  logic              fits;
  logic [ADDR_W-1:0] base_mem [N_EP];
  logic [MPS_W-1:0]  len_mem  [N_EP];

  always_comb begin
    need = '0;
    if (wk_en) need = wk_dbl ? (TOT_W'(wk_mps) << 1) : TOT_W'(wk_mps);
    sum  = total_q + need;
    fits = !ovf && (sum <= TOT_W'(MEM_BYTES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ovf     <= 1'b0;
      wk_idx  <= '0;
      total_q <= '0;
      alloc_v <= '0;
      dbl_v   <= '0;
    end else if (commit) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      ovf     <= 1'b0;
      wk_idx  <= '0;
      total_q <= '0;
      alloc_v <= '0;
      dbl_v   <= '0;
    end else if (busy) begin
      if (wk_en && fits) begin
        alloc_v[wk_idx] <= 1'b1;
        dbl_v[wk_idx]   <= wk_dbl;
        total_q         <= sum;
      end else if (wk_en) begin
        ovf <= 1'b1;
      end
      if (wk_idx == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        wk_idx <= wk_idx + 1'b1;
      end
    end
  end

  // Snapshot tables: one write per walk step.
  always_ff @(posedge clk) begin
    if (busy && !commit) begin
      base_mem[wk_idx] <= total_q[ADDR_W-1:0];
      len_mem[wk_idx]  <= wk_mps;
    end
  end

  assign lk_base = base_mem[lk_idx];
  assign lk_len  = len_mem[lk_idx];
endmodule

// File: rtl/ep_pingpong.sv
module ep_pingpong #(
  parameter int N_EP = 16,
  parameter int EP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            pkt_done,
  input  logic [EP_W-1:0] pkt_ep,
  input  logic            done,
  input  logic [N_EP-1:0] alloc_v,
  input  logic [N_EP-1:0] dbl_v,
  output logic [N_EP-1:0] half_v
);
  for (genvar i = 0; i < N_EP; i++) begin : g_sel
    logic half_q;

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        half_q <= 1'b0;
      end else if (pkt_done && done && pkt_ep == EP_W'(i) && alloc_v[i] && dbl_v[i]) begin
        half_q <= ~half_q;
      end
    end

    assign half_v[i] = half_q;
  end
endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc #(
  parameter int MEM_BYTES  = 8192,
  parameter int CTRL_BYTES = 64,
  parameter int N_DATA     = 7,
  parameter int MPS_W      = 11,
  localparam int N_EP      = 2 + 2 * N_DATA,
  localparam int EP_W      = $clog2(N_EP),
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [EP_W-1:0]   cfg_ep,
  input  logic              cfg_en,
  input  logic [MPS_W-1:0]  cfg_mps,
  input  logic              cfg_dbl,
  input  logic [1:0]        cfg_type,
  input  logic              commit,
  output logic              alloc_busy,
  output logic              alloc_done,
  output logic              alloc_ovf,
  input  logic              pkt_done,
  input  logic [EP_W-1:0]   pkt_ep,
  input  logic [EP_W-1:0]   lk_ep,
  output logic              lk_valid,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [MPS_W-1:0]  lk_len,
  output logic              lk_half,
  output logic [1:0]        lk_type
);
  logic [EP_W-1:0]   wk_idx;
  logic              wk_en;
  logic              wk_dbl;
  logic [MPS_W-1:0]  wk_mps;
  logic [N_EP-1:0]   alloc_v;
  logic [N_EP-1:0]   dbl_v;
  logic [N_EP-1:0]   half_v;
  logic [ADDR_W-1:0] sel_base;
  logic [MPS_W-1:0]  sel_len;
  logic [1:0]        sel_type;

  ep_cfg_regs #(
    .N_EP(N_EP), .EP_W(EP_W), .MPS_W(MPS_W), .CTRL_BYTES(CTRL_BYTES)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_en(cfg_en),
    .cfg_mps(cfg_mps), .cfg_dbl(cfg_dbl), .cfg_type(cfg_type),
    .wk_idx(wk_idx), .wk_en(wk_en), .wk_mps(wk_mps), .wk_dbl(wk_dbl),
    .lk_idx(lk_ep), .lk_type(sel_type)
  );

  ep_alloc_walker #(
    .N_EP(N_EP), .EP_W(EP_W), .MPS_W(MPS_W), .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)
  ) u_walk (
    .clk(clk), .rst(rst), .commit(commit),
    .wk_idx(wk_idx), .wk_en(wk_en), .wk_mps(wk_mps), .wk_dbl(wk_dbl),
    .busy(alloc_busy), .done(alloc_done), .ovf(alloc_ovf),
    .alloc_v(alloc_v), .dbl_v(dbl_v),
    .lk_idx(lk_ep), .lk_base(sel_base), .lk_len(sel_len)
  );

  ep_pingpong #(
    .N_EP(N_EP), .EP_W(EP_W)
  ) u_pp (
    .clk(clk), .rst(rst), .clear(commit),
    .pkt_done(pkt_done), .pkt_ep(pkt_ep), .done(alloc_done),
    .alloc_v(alloc_v), .dbl_v(dbl_v), .half_v(half_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0;
      lk_addr  <= '0;
      lk_len   <= '0;
      lk_half  <= 1'b0;
      lk_type  <= '0;
    end else begin
      lk_valid <= alloc_done && alloc_v[lk_ep];
      lk_addr  <= sel_base + (half_v[lk_ep] ? ADDR_W'(sel_len) : '0);
      lk_len   <= sel_len;
      lk_half  <= half_v[lk_ep];
      lk_type  <= sel_type;
    end
  end
endmodule

// File: rtl/ep_buf_alloc_chk.sv
module ep_buf_alloc_chk #(
  parameter int MEM_BYTES  = 8192,
  parameter int CTRL_BYTES = 64,
  parameter int EP_W       = 4,
  parameter int ADDR_W     = 13,
  parameter int MPS_W      = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              commit,
  input logic              alloc_busy,
  input logic              alloc_done,
  input logic              alloc_ovf,
  input logic [EP_W-1:0]   lk_ep,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic [MPS_W-1:0]  lk_len,
  input logic              lk_half
);
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (alloc_busy && !alloc_done && !alloc_ovf)); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (alloc_done && !commit) |=> alloc_done); // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(alloc_busy && alloc_done)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alloc_ovf && !commit) |=> alloc_ovf); // R7
  AST_IN_POOL: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ((ADDR_W + 2)'(lk_addr) + (ADDR_W + 2)'(lk_len) <= (ADDR_W + 2)'(MEM_BYTES))); // R7
  AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $past(alloc_done)); // R11
  AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(lk_ep) < EP_W'(2)) |-> (lk_len == MPS_W'(CTRL_BYTES) && !lk_half)); // R4
endmodule

bind ep_buf_alloc ep_buf_alloc_chk #(
  .MEM_BYTES(MEM_BYTES), .CTRL_BYTES(CTRL_BYTES),
  .EP_W(EP_W), .ADDR_W(ADDR_W), .MPS_W(MPS_W)
) u_chk (
  .clk(clk), .rst(rst), .commit(commit),
  .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_ovf(alloc_ovf),
  .lk_ep(lk_ep), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .lk_len(lk_len), .lk_half(lk_half)
);

// File: tb/ep_buf_alloc_tb.sv
`timescale 1ns/1ps
module ep_buf_alloc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_ep = '0;
  logic        cfg_en = 1'b0;
  logic [10:0] cfg_mps = '0;
  logic        cfg_dbl = 1'b0;
  logic [1:0]  cfg_type = '0;
  logic        commit = 1'b0;
  logic        alloc_busy, alloc_done, alloc_ovf;
  logic        pkt_done = 1'b0;
  logic [3:0]  pkt_ep = '0;
  logic [3:0]  lk_ep = '0;
  logic        lk_valid;
  logic [12:0] lk_addr;
  logic [10:0] lk_len;
  logic        lk_half;
  logic [1:0]  lk_type;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Model: live configuration and the snapshot taken at commit.
  int m_en[16], m_mps[16], m_dbl[16], m_type[16];
  int s_mps[16], s_dbl[16], e_base[16], e_valid[16], e_half[16];
  int e_ovf;

  always #2.5 clk = ~clk;

  ep_buf_alloc u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_en(cfg_en),
    .cfg_mps(cfg_mps), .cfg_dbl(cfg_dbl), .cfg_type(cfg_type), .commit(commit),
    .alloc_busy(alloc_busy), .alloc_done(alloc_done), .alloc_ovf(alloc_ovf),
    .pkt_done(pkt_done), .pkt_ep(pkt_ep), .lk_ep(lk_ep), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_len(lk_len), .lk_half(lk_half), .lk_type(lk_type)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_en[i] = (i < 2); m_mps[i] = (i < 2) ? 64 : 0; m_dbl[i] = 0;
      m_type[i] = (i < 2) ? 0 : 2; e_valid[i] = 0; e_half[i] = 0;
    end
    e_ovf = 0;
  endtask

  task automatic model_commit();
    int total = 0;
    e_ovf = 0;
    for (int i = 0; i < 16; i++) begin
      int need = m_en[i] ? (m_dbl[i] ? 2 * m_mps[i] : m_mps[i]) : 0;
      s_mps[i] = m_mps[i]; s_dbl[i] = m_dbl[i]; e_valid[i] = 0; e_half[i] = 0;
      if (m_en[i]) begin
        if (!e_ovf && total + need <= 8192) begin
          e_valid[i] = 1; e_base[i] = total; total += need;
        end else e_ovf = 1;
      end
    end
  endtask

  task automatic set_ep(int idx, int en, int mps, int dbl, int typ);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ep = 4'(idx); cfg_en = en[0]; cfg_mps = 11'(mps);
    cfg_dbl = dbl[0]; cfg_type = 2'(typ);
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx >= 2) begin
      m_en[idx] = en; m_mps[idx] = mps; m_dbl[idx] = dbl; m_type[idx] = typ;
    end
  endtask

  task automatic do_commit();
    int n = 0;
    @(negedge clk); commit = 1'b1;
    @(posedge clk); #1;
    check("R2", "busy after commit", int'(alloc_busy), 1);
    check("R2", "done cleared by commit", int'(alloc_done), 0);
    @(negedge clk); commit = 1'b0;
    model_commit();
    while (n < 40) begin
      @(posedge clk); #1; n++;
      if (alloc_done) break;
    end
    check("R2", "cycles from commit to done", n, 16);
    check("R7", "overflow flag", int'(alloc_ovf), e_ovf);
  endtask

  task automatic lookup(int idx, string req);
    @(negedge clk); lk_ep = 4'(idx);
    @(posedge clk); #1;
    check(req, $sformatf("valid slot %0d", idx), int'(lk_valid), e_valid[idx]);
    check("R11", $sformatf("type slot %0d", idx), int'(lk_type), m_type[idx]);
    if (e_valid[idx]) begin
      check(req, $sformatf("addr slot %0d", idx), int'(lk_addr),
            e_base[idx] + (e_half[idx] ? s_mps[idx] : 0));
      check(req, $sformatf("len slot %0d", idx), int'(lk_len), s_mps[idx]);
      check(req, $sformatf("half slot %0d", idx), int'(lk_half), e_half[idx]);
    end
  endtask

  task automatic pulse_pkt(int idx);
    @(negedge clk); pkt_done = 1'b1; pkt_ep = 4'(idx);
    @(negedge clk); pkt_done = 1'b0;
    if (e_valid[idx] && s_dbl[idx]) e_half[idx] = 1 - e_half[idx];
  endtask

  task automatic t_reset();
    check("R1", "done after reset", int'(alloc_done), 0);
    check("R1", "busy after reset", int'(alloc_busy), 0);
    check("R1", "ovf after reset", int'(alloc_ovf), 0);
    lookup(0, "R1");
  endtask

  task automatic t_basic();
    set_ep(2, 1, 512, 0, 2);   // OUT1 single bulk
    set_ep(3, 1, 200, 1, 1);   // OUT2 double iso
    set_ep(4, 0, 300, 0, 2);   // OUT3 disabled
    set_ep(9, 1, 64, 1, 3);    // IN1 double interrupt
    set_ep(15, 1, 1024, 0, 2); // IN7 single bulk
    do_commit();
    for (int i = 0; i < 16; i++)
      lookup(i, (i < 2) ? "R4" : (i == 4 || !m_en[i]) ? "R5" : (m_dbl[i] ? "R6" : "R3"));
  endtask

  task automatic t_pingpong();
    pulse_pkt(9);  lookup(9, "R8");
    pulse_pkt(9);  lookup(9, "R8");
    pulse_pkt(3);  lookup(3, "R8");
    pulse_pkt(2);  lookup(2, "R9");
    pulse_pkt(0);  lookup(0, "R9");
    do_commit();
    lookup(3, "R10");
  endtask

  task automatic t_late_cfg();
    set_ep(2, 0, 100, 1, 2);
    set_ep(5, 1, 256, 0, 2);
    set_ep(0, 1, 900, 1, 1);   // control slot write must be dropped
    lookup(2, "R12");
    lookup(5, "R12");
    do_commit();
    lookup(0, "R4");
    lookup(1, "R4");
    lookup(2, "R12");
    lookup(5, "R12");
  endtask

  task automatic t_overflow();
    for (int i = 2; i < 16; i++) set_ep(i, 1, 1024, 1, 2);
    do_commit();
    for (int i = 2; i < 16; i++) lookup(i, "R7");
    for (int i = 2; i < 16; i++) set_ep(i, 0, 0, 0, 2);
    set_ep(2, 1, 1024, 1, 2);
    set_ep(3, 1, 1024, 1, 2);
    set_ep(4, 1, 1024, 1, 2);
    set_ep(5, 1, 1024, 0, 2);
    set_ep(6, 1, 896, 0, 2);   // total becomes exactly 8192
    do_commit();
    for (int i = 2; i < 8; i++) lookup(i, "R7");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_pingpong();
    t_late_cfg();
    t_overflow();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule